// File: doc/BRIEF.md
# Half-Rate DDR Output Path

This block sits between core logic and an output pad. It turns a small word of core data into a serial pin value and carries the pad's output enable alongside it. A two-bit mode input picks one of four behaviours. In combinational SDR the pin follows the core. In registered SDR the pin is retimed once on the full-rate clock. In full-rate DDR the pin carries two bits per full-rate cycle. In half-rate DDR a four-bit word is accepted once per half-rate cycle and serialized over two full-rate cycles.

The design has two lanes built from the same module: one for data and one for the enable, so both see the same pipeline in every mode. Each lane has a conversion stage and a DDR output register. The conversion stage latches the wide word on the half-rate clock and hands bit pairs to the full-rate domain. The DDR output register presents the first bit of a pair while the full-rate clock is high and the second while it is low. Modes that do not use the conversion stage or the output registers route around them. The full-rate clock runs at twice the half-rate frequency, with its rising edges aligned to the half-rate rising edges.

Top module: `ddr_out_path`

## Requirements
- R1: Mode encoding is 0 = combinational SDR, 1 = registered SDR, 2 = full-rate DDR, 3 = half-rate DDR. In any registered mode a new input does not reach the pin before the next rising edge of the full-rate clock.
- R2: In mode 0 the pin data equals data_in[0] and the pin enable equals oe_in[0], with no clock edge in between.
- R3: In mode 1, data_in[0] is captured on a rising full-rate edge and drives the pin for the whole following full-rate cycle, in both clock phases.
- R4: In mode 2, data_in[1:0] is captured on a rising full-rate edge. In the following cycle the pin shows bit 0 while the full-rate clock is high and bit 1 while it is low.
- R5: In mode 3, data_in[3:0] is latched on a rising half-rate edge. Starting at the next rising full-rate edge, the pin sends bits 0 and 1 (high phase, then low phase) in one full-rate cycle and bits 2 and 3 in the next.
- R6: The pin enable is produced from oe_in by the same path as the data, so in every mode it has the same latency and bit order as the pin data.
- R7: The low-phase bit reaches the pin from a register loaded on the falling full-rate edge. Input changes made during the low phase therefore do not disturb the pin.
- R8: While reset is asserted, both pin outputs are 0 in every mode. Reset takes effect at once and is released in step with each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fr | input | 1 | Full-rate clock |
| clk_hr | input | 1 | Half-rate clock, rising edges aligned with clk_fr |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Output mode select (encoding in R1) |
| data_in | input | 4 | Core data word |
| oe_in | input | 4 | Core output-enable word |
| pin_data | output | 1 | Value to the pad driver |
| pin_oe | output | 1 | Output enable to the pad driver |

## Verification
Every pin value is sampled in the middle of both clock phases. This catches a DDR register that swaps the high and low bits, or a half-rate stage that sends the pairs in the wrong order or one cycle late. The enable word uses patterns different from the data word, so an enable lane with a different latency or bit order shows up as a mismatch on pin_oe. One check changes the input during the low phase, which exposes a low bit taken straight from the rising-edge register. Reset is applied while combinational mode has all-ones inputs, so an output left ungated by reset is caught.

// File: rtl/ddr_out_pkg.sv
package ddr_out_pkg;

  typedef enum logic [1:0] {
    MODE_SDR_COMB = 2'd0,
    MODE_SDR_REG  = 2'd1,
    MODE_DDR_FULL = 2'd2,
    MODE_DDR_HALF = 2'd3
  } out_mode_e;

endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/ddr_hr_conv.sv
module ddr_hr_conv #(
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk_hr,
  input  logic              rst_hr_n,
  input  logic              clk_fr,
  input  logic              rst_fr_n,
  input  logic [WORD_W-1:0] word_i,
  output logic [1:0]        pair_o
);

  localparam int unsigned PAIRS = WORD_W / 2;
  localparam int unsigned IDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  // half-rate side: word latch and a toggle marking each new word
  logic [WORD_W-1:0] word_q, word_d;
  logic              tog_q, tog_d;

  always_comb begin
    word_d = word_i;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge clk_hr or negedge rst_hr_n) begin
    if (!rst_hr_n) begin
      word_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      tog_q  <= tog_d;
    end
  end

  // full-rate side: detect a fresh word, then step through its pairs
  logic             seen_q, seen_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] sel_idx;
  logic             new_word;

  always_comb begin
    new_word = tog_q ^ seen_q;
    sel_idx  = new_word ? '0 : idx_q;
    pair_o   = word_q[2*int'(sel_idx) +: 2];
    seen_d   = tog_q;
    if (sel_idx == IDX_W'(PAIRS-1)) idx_d = '0;
    else                            idx_d = sel_idx + IDX_W'(1);
  end

  always_ff @(posedge clk_fr or negedge rst_fr_n) begin
    if (!rst_fr_n) begin
      seen_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      seen_q <= seen_d;
      idx_q  <= idx_d;
    end
  end

  // R5: a half-rate word is announced on exactly one full-rate edge
  a_r5_single_new: assert property (@(posedge clk_fr) disable iff (!rst_fr_n)
    new_word |=> !new_word);

  // R5: after the first pair the stage moves on to the second pair
  a_r5_idx_restart: assert property (@(posedge clk_fr) disable iff (!rst_fr_n)
    new_word |=> (idx_q == IDX_W'(1)));

endmodule

// File: rtl/ddr_out_reg.sv
module ddr_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d_rise,
  input  logic d_fall,
  output logic q
);

  logic rise_q, fall_q, fall_neg_q;
  logic rise_d, fall_d, fall_neg_d;

  always_comb begin
    rise_d     = d_rise;
    fall_d     = d_fall;
    fall_neg_d = fall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  // low-phase bit is re-timed on the falling edge so the output mux never races
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_neg_q <= 1'b0;
    else        fall_neg_q <= fall_neg_d;
  end

  assign q = clk ? rise_q : fall_neg_q;

  // R7: by each rising edge the falling-edge stage holds the pending low bit
  a_r7_fall_stage: assert property (@(posedge clk) disable iff (!rst_n)
    fall_neg_q == fall_q);

endmodule

// File: rtl/ddr_lane.sv
module ddr_lane
  import ddr_out_pkg::*;
#(
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk_fr,
  input  logic              clk_hr,
  input  logic              rst_fr_n,
  input  logic              rst_hr_n,
  input  out_mode_e         mode,
  input  logic [WORD_W-1:0] bits_i,
  output logic              pin_o
);

  logic [1:0] conv_pair;
  logic       bit_rise, bit_fall;
  logic       ddr_q;

  ddr_hr_conv #(.WORD_W(WORD_W)) u_conv (
    .clk_hr  (clk_hr),
    .rst_hr_n(rst_hr_n),
    .clk_fr  (clk_fr),
    .rst_fr_n(rst_fr_n),
    .word_i  (bits_i),
    .pair_o  (conv_pair)
  );

  always_comb begin
    case (mode)
      MODE_DDR_FULL: begin
        bit_rise = bits_i[0];
        bit_fall = bits_i[1];
      end
      MODE_DDR_HALF: begin
        bit_rise = conv_pair[0];
        bit_fall = conv_pair[1];
      end
      default: begin
        bit_rise = bits_i[0];
        bit_fall = bits_i[0];
      end
    endcase
  end

  ddr_out_reg u_oreg (
    .clk   (clk_fr),
    .rst_n (rst_fr_n),
    .d_rise(bit_rise),
    .d_fall(bit_fall),
    .q     (ddr_q)
  );

  assign pin_o = (mode == MODE_SDR_COMB) ? bits_i[0] : ddr_q;

  // R1: the mode select must always be a defined code while running
  a_r1_mode_known: assert property (@(posedge clk_fr) disable iff (!rst_fr_n)
    !$isunknown(mode));

endmodule

// File: rtl/ddr_out_path.sv
module ddr_out_path
  import ddr_out_pkg::*;
#(
  parameter int unsigned WORD_W     = 4,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_fr,
  input  logic              clk_hr,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] data_in,
  input  logic [WORD_W-1:0] oe_in,
  output logic              pin_data,
  output logic              pin_oe
);

  localparam int unsigned LANES = 2;

  logic rst_fr_n, rst_hr_n;

  ddr_rst_sync #(.STAGES(RST_STAGES)) u_rs_fr (
    .clk(clk_fr), .rst_n_i(rst_n), .rst_n_o(rst_fr_n)
  );

  ddr_rst_sync #(.STAGES(RST_STAGES)) u_rs_hr (
    .clk(clk_hr), .rst_n_i(rst_n), .rst_n_o(rst_hr_n)
  );

  out_mode_e                      mode_e;
  logic [LANES-1:0][WORD_W-1:0]   lane_bits;
  logic [LANES-1:0]               lane_pin;

  assign mode_e    = out_mode_e'(mode);
  assign lane_bits = {oe_in, data_in};

  // lane 0 carries data, lane 1 the enable: identical structure keeps latency equal
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ddr_lane #(.WORD_W(WORD_W)) u_lane (
      .clk_fr  (clk_fr),
      .clk_hr  (clk_hr),
      .rst_fr_n(rst_fr_n),
      .rst_hr_n(rst_hr_n),
      .mode    (mode_e),
      .bits_i  (lane_bits[g]),
      .pin_o   (lane_pin[g])
    );
  end

  assign pin_data = rst_fr_n & lane_pin[0];
  assign pin_oe   = rst_fr_n & lane_pin[1];

endmodule

// File: tb/ddr_out_path_tb.sv
module ddr_out_path_tb;

  logic       clk_fr, clk_hr, rst_n;
  logic [1:0] mode;
  logic [3:0] data_in, oe_in;
  logic       pin_data, pin_oe;

  ddr_out_path u_dut (
    .clk_fr(clk_fr), .clk_hr(clk_hr), .rst_n(rst_n), .mode(mode),
    .data_in(data_in), .oe_in(oe_in), .pin_data(pin_data), .pin_oe(pin_oe)
  );

  initial clk_fr = 1'b0;
  always #10 clk_fr = ~clk_fr;

  initial clk_hr = 1'b0;
  always @(posedge clk_fr) clk_hr <= ~clk_hr;

  typedef struct {
    int    slot;
    logic  d;
    logic  oe;
    string req;
  } exp_t;

  exp_t q[$];
  int   slot = 0;
  int   n_chk = 0;
  int   n_bad = 0;

  task automatic chk(string req, logic act_d, logic exp_d, logic act_oe, logic exp_oe);
    n_chk++;
    if (act_d !== exp_d || act_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s: data=%b oe=%b expected data=%b oe=%b at %0t",
               req, act_d, act_oe, exp_d, exp_oe, $time);
    end
  endtask

  // monitor: one sample in the middle of each clock phase
  task automatic sample();
    if (q.size() > 0 && q[0].slot == slot) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, pin_data, e.d, pin_oe, e.oe);
    end
    slot++;
  endtask

  always @(posedge clk_fr) begin #5; sample(); end
  always @(negedge clk_fr) begin #5; sample(); end

  // drivers: set inputs just after a rising edge and queue the expected pin values
  task automatic drive_comb(logic d, logic oe);
    @(posedge clk_fr); #2;
    mode = 2'd0; data_in = {3'b000, d}; oe_in = {3'b111, oe};
    q.push_back('{slot,     d, oe, "R2"});
    q.push_back('{slot + 1, d, oe, "R2"});
  endtask

  task automatic drive_reg(logic d, logic oe);
    @(posedge clk_fr); #2;
    mode = 2'd1; data_in = {3'b000, d}; oe_in = {3'b000, oe};
    q.push_back('{slot + 2, d, oe, "R3"});
    q.push_back('{slot + 3, d, oe, "R3"});
  endtask

  task automatic drive_ddr(logic [1:0] d, logic [1:0] oe);
    @(posedge clk_fr); #2;
    mode = 2'd2; data_in = {2'b00, d}; oe_in = {2'b11, oe};
    q.push_back('{slot + 2, d[0], oe[0], "R4"});
    q.push_back('{slot + 3, d[1], oe[1], "R4"});
  endtask

  task automatic drive_half(logic [3:0] w, logic [3:0] oe);
    @(posedge clk_hr); #2;
    mode = 2'd3; data_in = w; oe_in = oe;
    for (int i = 0; i < 4; i++)
      q.push_back('{slot + 6 + i, w[i], oe[i], "R5"});
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk_fr);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: expired, actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; data_in = 4'hF; oe_in = 4'hF;
    #55;
    // R8: comb mode with all-ones inputs, outputs held low in reset
    chk("R8", pin_data, 1'b0, pin_oe, 1'b0);
    @(negedge clk_fr); rst_n = 1'b1;
    idle(4);

    // R2 / R6: combinational path, several patterns
    drive_comb(1'b1, 1'b0);
    drive_comb(1'b0, 1'b1);
    drive_comb(1'b1, 1'b1);
    @(posedge clk_fr); #2; data_in = 4'h0; oe_in = 4'h1; #1;
    chk("R2", pin_data, 1'b0, pin_oe, 1'b1);
    idle(3);

    // R1: registered mode does not pass a new input before the edge
    @(posedge clk_fr); #2; mode = 2'd1; data_in = 4'h0; oe_in = 4'h0;
    @(posedge clk_fr); #2; data_in = 4'h1; oe_in = 4'h1; #3;
    chk("R1", pin_data, 1'b0, pin_oe, 1'b0);
    idle(2);

    // R3 / R6
    drive_reg(1'b0, 1'b1);
    drive_reg(1'b1, 1'b0);
    drive_reg(1'b1, 1'b1);
    drive_reg(1'b0, 1'b0);
    idle(4);

    // R4 / R6: all bit pairs, enable patterns differ from data
    drive_ddr(2'b01, 2'b10);
    drive_ddr(2'b10, 2'b11);
    drive_ddr(2'b11, 2'b00);
    drive_ddr(2'b00, 2'b01);
    idle(4);

    // R7: change input during low phase, pin keeps the registered low bit
    @(posedge clk_fr); #2; mode = 2'd2; data_in = 4'b0010; oe_in = 4'b0001;
    @(posedge clk_fr);
    @(negedge clk_fr); #2; data_in = 4'b0001; oe_in = 4'b0010; #4;
    chk("R7", pin_data, 1'b1, pin_oe, 1'b0);
    idle(4);

    // R5 / R6: half-rate words, back to back
    drive_half(4'b0110, 4'b1001);
    drive_half(4'b1011, 4'b0100);
    drive_half(4'b0001, 4'b1110);
    drive_half(4'b1000, 4'b0111);
    idle(8);

    // R8: asynchronous reset mid-run in registered mode
    @(posedge clk_fr); #2; mode = 2'd1; data_in = 4'h1; oe_in = 4'h1;
    idle(2); #3;
    chk("R3", pin_data, 1'b1, pin_oe, 1'b1);
    rst_n = 1'b0; #1;
    chk("R8", pin_data, 1'b0, pin_oe, 1'b0);
    idle(2);
    rst_n = 1'b1;
    idle(4);

    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: pending=%0d expected=0", q.size());
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule